// File: doc/BRIEF.md
# Hunt-Mode Transparent Serial Receiver

The receiver takes a raw serial bit stream, one bit per `bit_vld_i` strobe, and stays in a hunt state until it locks onto the stream. Lock comes either from a pulse on `sync_pulse_i` or from a 16-bit sync pattern matching the most recent bits. Once locked, the receiver packs bits into bytes, most significant bit first. It can bit-reverse each byte, and passes the bytes through a small FIFO into buffers owned by a descriptor ring.

Each descriptor carries an empty flag, which the host sets with `arm_vld_i`, and an interrupt-enable flag. When a buffer fills, the receiver closes its descriptor. Closing clears the empty flag and reports the byte count and a CRC verdict on the close port. It pulses `irq_o` if the descriptor asked for it, then moves to the next descriptor. A missing buffer, a FIFO overrun, loss of carrier, a disabled receiver or an explicit command sends the receiver back to hunting. A partly filled buffer is closed at that point.

Top module: `hunt_rx`

## Requirements
- R1: After reset, and while out of sync, no byte is offered on the write port. After reset `in_sync_o` is 0 and `desc_empty_o` is all zeros.
- R2: In pattern mode (`pulse_mode_i`=0), lock occurs at the bit whose arrival makes the last 16 received bits, oldest in bit 15, equal `sync_pat_i`. The next bit is bit 7 (MSB) of the first byte.
- R3: In pulse mode (`pulse_mode_i`=1), a bit strobed together with `sync_pulse_i` while hunting locks the receiver, and that bit is bit 7 of the first byte.
- R4: When BUF_LEN bytes have been written to a descriptor, the receiver closes it one cycle after the last write. Closing clears its `desc_empty_o` bit and reports its index and a count of BUF_LEN. `irq_o` is high in the close cycle exactly when the descriptor was armed with `arm_ie_i`=1.
- R5: If a byte waits at the FIFO head while the current descriptor is not empty, the receiver pulses `bsy_o` for one cycle and returns to hunt with the FIFO flushed. It also pulses `irq_o` when `bsy_ie_i`=1.
- R6: `hunt_cmd_i`, `cd_i`=0 or `en_i`=0 return the receiver to hunt. A buffer holding N>0 bytes is then closed with count N.
- R7: A byte completing while the FIFO holds its full capacity is dropped. The receiver pulses `ovr_o` and returns to hunt.
- R8: FIFO capacity is FIFO_D bytes with `narrow_i`=0 and 1 byte with `narrow_i`=1.
- R9: With `rev_i`=1 each byte is bit-reversed (bit 0 becomes bit 7) before it enters the FIFO.
- R10: A CRC runs over every stored byte of a buffer, MSB first, starting at 16'hFFFF with no final inversion. The polynomial is 16'h1021 with `crc_sel_i`=0 and 16'h8005 with `crc_sel_i`=1. `close_crc_err_o` is 1 when the register is nonzero after the buffer's last byte, so a buffer ending in its own CRC, high byte first, passes.
- R11: Descriptors are used in index order, and the index wraps from DESC_N-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Receiver enable |
| bit_i | input | 1 | Serial data bit |
| bit_vld_i | input | 1 | Bit strobe |
| sync_pulse_i | input | 1 | External sync pulse |
| pulse_mode_i | input | 1 | 1: lock on pulse, 0: lock on pattern |
| sync_pat_i | input | PAT_W | Sync pattern |
| cd_i | input | 1 | Carrier detect |
| hunt_cmd_i | input | 1 | Force return to hunt |
| rev_i | input | 1 | Bit-reverse each byte |
| narrow_i | input | 1 | Reduce FIFO capacity to one byte |
| crc_sel_i | input | 1 | CRC polynomial select |
| arm_vld_i | input | 1 | Set empty flag of a descriptor |
| arm_idx_i | input | IW | Descriptor to arm |
| arm_ie_i | input | 1 | Interrupt enable stored with the arm |
| bsy_ie_i | input | 1 | Interrupt enable for busy |
| wr_rdy_i | input | 1 | Memory accepts the offered byte |
| wr_vld_o | output | 1 | Byte offered for storage |
| wr_idx_o | output | IW | Descriptor of offered byte |
| wr_off_o | output | OW | Offset within buffer |
| wr_data_o | output | 8 | Offered byte |
| close_vld_o | output | 1 | Descriptor closed |
| close_idx_o | output | IW | Closed descriptor |
| close_cnt_o | output | CW | Bytes in closed buffer |
| close_crc_err_o | output | 1 | CRC mismatch on closed buffer |
| bsy_o | output | 1 | Busy event pulse |
| ovr_o | output | 1 | Overrun event pulse |
| irq_o | output | 1 | Interrupt pulse |
| in_sync_o | output | 1 | Receiver locked |
| desc_empty_o | output | DESC_N | Empty flags of all descriptors |

## Verification
The bench builds the block with DESC_N=4 and BUF_LEN=4, keeping FIFO_D=4 and PAT_W=16. A four-byte buffer holds two payload bytes and a CRC, so frames are short. Four descriptors make the wrap from index 3 to 0 reachable after a handful of frames, and a still-owned descriptor turns up soon after, which triggers busy. Holding the memory side not ready lets the bench fill the FIFO at both capacities and observe the overrun on exactly the second and the fifth byte.

// File: rtl/hunt_rx_pkg.sv
package hunt_rx_pkg;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  function automatic logic [15:0] crc16_upd(input logic [15:0] c, input logic [7:0] d,
                                            input logic sel);
    logic [15:0] r;
    logic [15:0] poly;
    poly = sel ? 16'h8005 : 16'h1021;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ poly;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] d);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = d[7-i];
    return r;
  endfunction
endpackage

// File: rtl/hunt_rx_sync.sv
module hunt_rx_sync #(
  parameter int PAT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             bit_vld_i,
  input  logic             sync_pulse_i,
  input  logic             pulse_mode_i,
  input  logic [PAT_W-1:0] sync_pat_i,
  input  logic             rev_i,
  input  logic             go_hunt_i,
  output logic             in_sync_o,
  output logic             byte_vld_o,
  output logic [7:0]       byte_o
);
  import hunt_rx_pkg::*;

  logic [PAT_W-1:0] sh_q;
  logic [PAT_W-1:0] sh_nx;
  logic             sync_q;
  logic [2:0]       cnt_q;
  logic [6:0]       acc_q;
  logic [7:0]       raw;

  assign sh_nx = {sh_q[PAT_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      sync_q <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
    end else begin
      if (bit_vld_i) sh_q <= sh_nx;
      if (go_hunt_i) begin
        sync_q <= 1'b0;
        cnt_q  <= '0;
      end else if (!sync_q) begin
        if (bit_vld_i) begin
          if (pulse_mode_i && sync_pulse_i) begin
            sync_q <= 1'b1;
            cnt_q  <= 3'd1;
            acc_q  <= {6'b0, bit_i};
          end else if (!pulse_mode_i && sh_nx == sync_pat_i) begin
            sync_q <= 1'b1;
            cnt_q  <= '0;
          end
        end
      end else if (bit_vld_i) begin
        cnt_q <= cnt_q + 3'd1;
        acc_q <= {acc_q[5:0], bit_i};
      end
    end
  end

  assign raw        = {acc_q, bit_i};
  assign byte_vld_o = sync_q & bit_vld_i & (cnt_q == 3'd7);
  assign byte_o     = rev_i ? rev8(raw) : raw;
  assign in_sync_o  = sync_q;
endmodule

// File: rtl/hunt_rx_fifo.sv
module hunt_rx_fifo #(
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int NW = $clog2(DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       flush_i,
  input  logic       narrow_i,
  input  logic       push_i,
  input  logic [7:0] din_i,
  input  logic       pop_i,
  output logic [7:0] dout_o,
  output logic       nempty_o,
  output logic       full_o
);
  // DEPTH is a power of two so pointers wrap naturally
  logic [7:0]    mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [NW-1:0] n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
      n_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (flush_i) begin
      wp_q <= '0;
      rp_q <= '0;
      n_q  <= '0;
    end else begin
      if (push_i) begin
        mem_q[wp_q] <= din_i;
        wp_q        <= wp_q + 1'b1;
      end
      if (pop_i) rp_q <= rp_q + 1'b1;
      if (push_i && !pop_i)      n_q <= n_q + 1'b1;
      else if (pop_i && !push_i) n_q <= n_q - 1'b1;
    end
  end

  assign dout_o   = mem_q[rp_q];
  assign nempty_o = n_q != '0;
  assign full_o   = narrow_i ? (n_q != '0) : (n_q == NW'(DEPTH));
endmodule

// File: rtl/hunt_rx_ring.sv
module hunt_rx_ring #(
  parameter int DESC_N  = 8,
  parameter int BUF_LEN = 16,
  localparam int IW = $clog2(DESC_N),
  localparam int OW = $clog2(BUF_LEN),
  localparam int CW = $clog2(BUF_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              crc_sel_i,
  input  logic              arm_vld_i,
  input  logic [IW-1:0]     arm_idx_i,
  input  logic              arm_ie_i,
  input  logic              head_vld_i,
  input  logic [7:0]        head_i,
  input  logic              wr_rdy_i,
  output logic              pop_o,
  output logic              bsy_req_o,
  output logic              wr_vld_o,
  output logic [IW-1:0]     wr_idx_o,
  output logic [OW-1:0]     wr_off_o,
  output logic              close_vld_o,
  output logic [IW-1:0]     close_idx_o,
  output logic [CW-1:0]     close_cnt_o,
  output logic              close_crc_err_o,
  output logic              close_irq_o,
  output logic [DESC_N-1:0] desc_empty_o
);
  import hunt_rx_pkg::*;

  logic [DESC_N-1:0] empty_q, ie_q;
  logic [IW-1:0]     cur_q;
  logic [OW-1:0]     off_q;
  logic [15:0]       crc_q, crc_nx;
  logic              full_close, part_close;

  assign crc_nx     = crc16_upd(crc_q, head_i, crc_sel_i);
  assign wr_vld_o   = head_vld_i & empty_q[cur_q] & !flush_i;
  assign pop_o      = wr_vld_o & wr_rdy_i;
  assign bsy_req_o  = head_vld_i & !empty_q[cur_q];
  assign full_close = pop_o & (off_q == OW'(BUF_LEN - 1));
  assign part_close = flush_i & (off_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q         <= '0;
      ie_q            <= '0;
      cur_q           <= '0;
      off_q           <= '0;
      crc_q           <= CRC_INIT;
      close_vld_o     <= 1'b0;
      close_idx_o     <= '0;
      close_cnt_o     <= '0;
      close_crc_err_o <= 1'b0;
      close_irq_o     <= 1'b0;
    end else begin
      close_vld_o <= 1'b0;
      close_irq_o <= 1'b0;
      if (pop_o) begin
        crc_q <= crc_nx;
        off_q <= off_q + 1'b1;
      end
      if (full_close || part_close) begin
        empty_q[cur_q]  <= 1'b0;
        close_vld_o     <= 1'b1;
        close_idx_o     <= cur_q;
        close_cnt_o     <= full_close ? CW'(BUF_LEN) : CW'(off_q);
        close_crc_err_o <= full_close ? (crc_nx != 16'h0) : (crc_q != 16'h0);
        close_irq_o     <= ie_q[cur_q];
        cur_q           <= (cur_q == IW'(DESC_N - 1)) ? '0 : cur_q + 1'b1;
        off_q           <= '0;
        crc_q           <= CRC_INIT;
      end
      if (arm_vld_i) begin
        empty_q[arm_idx_i] <= 1'b1;
        ie_q[arm_idx_i]    <= arm_ie_i;
      end
    end
  end

  assign wr_idx_o     = cur_q;
  assign wr_off_o     = off_q;
  assign desc_empty_o = empty_q;
endmodule

// File: rtl/hunt_rx.sv
module hunt_rx #(
  parameter int DESC_N  = 8,
  parameter int BUF_LEN = 16,
  parameter int FIFO_D  = 4,
  parameter int PAT_W   = 16,
  localparam int IW = $clog2(DESC_N),
  localparam int OW = $clog2(BUF_LEN),
  localparam int CW = $clog2(BUF_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              bit_i,
  input  logic              bit_vld_i,
  input  logic              sync_pulse_i,
  input  logic              pulse_mode_i,
  input  logic [PAT_W-1:0]  sync_pat_i,
  input  logic              cd_i,
  input  logic              hunt_cmd_i,
  input  logic              rev_i,
  input  logic              narrow_i,
  input  logic              crc_sel_i,
  input  logic              arm_vld_i,
  input  logic [IW-1:0]     arm_idx_i,
  input  logic              arm_ie_i,
  input  logic              bsy_ie_i,
  input  logic              wr_rdy_i,
  output logic              wr_vld_o,
  output logic [IW-1:0]     wr_idx_o,
  output logic [OW-1:0]     wr_off_o,
  output logic [7:0]        wr_data_o,
  output logic              close_vld_o,
  output logic [IW-1:0]     close_idx_o,
  output logic [CW-1:0]     close_cnt_o,
  output logic              close_crc_err_o,
  output logic              bsy_o,
  output logic              ovr_o,
  output logic              irq_o,
  output logic              in_sync_o,
  output logic [DESC_N-1:0] desc_empty_o
);
  logic       byte_vld, push, pop, ovr, hunt_req, go_hunt;
  logic       fifo_nempty, fifo_full, bsy_req, close_irq, bsy_irq_q;
  logic [7:0] byte_d, head;

  // overrun is kept out of hunt_req to avoid a combinational loop
  assign hunt_req = hunt_cmd_i | !cd_i | !en_i | bsy_req;
  assign ovr      = byte_vld & fifo_full & !hunt_req;
  assign push     = byte_vld & !fifo_full & !hunt_req;
  assign go_hunt  = hunt_req | ovr;

  hunt_rx_sync #(.PAT_W(PAT_W)) u_sync (
    .clk_i, .rst_ni, .bit_i, .bit_vld_i, .sync_pulse_i, .pulse_mode_i, .sync_pat_i, .rev_i,
    .go_hunt_i(go_hunt), .in_sync_o, .byte_vld_o(byte_vld), .byte_o(byte_d)
  );

  hunt_rx_fifo #(.DEPTH(FIFO_D)) u_fifo (
    .clk_i, .rst_ni, .flush_i(go_hunt), .narrow_i, .push_i(push), .din_i(byte_d),
    .pop_i(pop), .dout_o(head), .nempty_o(fifo_nempty), .full_o(fifo_full)
  );

  hunt_rx_ring #(.DESC_N(DESC_N), .BUF_LEN(BUF_LEN)) u_ring (
    .clk_i, .rst_ni, .flush_i(go_hunt), .crc_sel_i, .arm_vld_i, .arm_idx_i, .arm_ie_i,
    .head_vld_i(fifo_nempty), .head_i(head), .wr_rdy_i, .pop_o(pop), .bsy_req_o(bsy_req),
    .wr_vld_o, .wr_idx_o, .wr_off_o, .close_vld_o, .close_idx_o, .close_cnt_o,
    .close_crc_err_o, .close_irq_o(close_irq), .desc_empty_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bsy_o     <= 1'b0;
      ovr_o     <= 1'b0;
      bsy_irq_q <= 1'b0;
    end else begin
      bsy_o     <= bsy_req;
      ovr_o     <= ovr;
      bsy_irq_q <= bsy_req & bsy_ie_i;
    end
  end

  assign wr_data_o = head;
  assign irq_o     = close_irq | bsy_irq_q;
endmodule

// File: rtl/hunt_rx_chk.sv
module hunt_rx_chk #(
  parameter int DESC_N  = 8,
  parameter int BUF_LEN = 16,
  localparam int IW = $clog2(DESC_N),
  localparam int CW = $clog2(BUF_LEN + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_sync_o,
  input logic              wr_vld_o,
  input logic              hunt_cmd_i,
  input logic              bsy_o,
  input logic              ovr_o,
  input logic              close_vld_o,
  input logic [IW-1:0]     close_idx_o,
  input logic [CW-1:0]     close_cnt_o,
  input logic [DESC_N-1:0] desc_empty_o
);
  logic          seen_q;
  logic [IW-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (close_vld_o) begin
      seen_q <= 1'b1;
      last_q <= close_idx_o;
    end
  end

  // R1
  no_store_in_hunt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_sync_o |-> !wr_vld_o);
  // R4
  close_owned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_vld_o |-> !desc_empty_o[close_idx_o]);
  // R4
  close_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_vld_o |-> (close_cnt_o != '0) && (close_cnt_o <= CW'(BUF_LEN)));
  // R5
  bsy_hunt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bsy_o |-> !in_sync_o);
  // R7
  ovr_hunt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> !in_sync_o);
  // R6
  cmd_hunt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hunt_cmd_i |=> !in_sync_o);
  // R11
  ring_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close_vld_o && seen_q) |->
      close_idx_o == ((last_q == IW'(DESC_N - 1)) ? '0 : last_q + 1'b1));
endmodule

bind hunt_rx hunt_rx_chk #(.DESC_N(DESC_N), .BUF_LEN(BUF_LEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_sync_o(in_sync_o), .wr_vld_o(wr_vld_o),
  .hunt_cmd_i(hunt_cmd_i), .bsy_o(bsy_o), .ovr_o(ovr_o), .close_vld_o(close_vld_o),
  .close_idx_o(close_idx_o), .close_cnt_o(close_cnt_o), .desc_empty_o(desc_empty_o)
);

// File: tb/sim_hunt_rx.sv
module sim_hunt_rx;
  localparam int DN = 4, BL = 4;
  localparam logic [15:0] PAT = 16'hA5C3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, b = 0, bv = 0, sp = 0, pm = 0, cd = 0, hc = 0, rv = 0, nar = 0, cs = 0;
  logic av = 0, aie = 0, bie = 0, rdy = 1;
  logic [1:0] aidx = 0;
  logic wv, cv, cerr, bsy, ovr, irq, ins;
  logic [1:0] widx, woff, cidx;
  logic [7:0] wdat;
  logic [2:0] ccnt;
  logic [3:0] demp;

  int tests = 0, fails = 0, nw = 0, nc = 0, nb = 0, no = 0, nbirq = 0, exp_cur = 0;
  int wd_a [256], wi_a [256], ci_a [64], cc_a [64], ce_a [64], cq_a [64];

  always #5 clk = ~clk;

  hunt_rx #(.DESC_N(DN), .BUF_LEN(BL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .bit_i(b), .bit_vld_i(bv), .sync_pulse_i(sp),
    .pulse_mode_i(pm), .sync_pat_i(PAT), .cd_i(cd), .hunt_cmd_i(hc), .rev_i(rv),
    .narrow_i(nar), .crc_sel_i(cs), .arm_vld_i(av), .arm_idx_i(aidx), .arm_ie_i(aie),
    .bsy_ie_i(bie), .wr_rdy_i(rdy), .wr_vld_o(wv), .wr_idx_o(widx), .wr_off_o(woff),
    .wr_data_o(wdat), .close_vld_o(cv), .close_idx_o(cidx), .close_cnt_o(ccnt),
    .close_crc_err_o(cerr), .bsy_o(bsy), .ovr_o(ovr), .irq_o(irq), .in_sync_o(ins),
    .desc_empty_o(demp)
  );

  always @(negedge clk) begin
    if (wv && rdy) begin wd_a[nw % 256] = wdat; wi_a[nw % 256] = widx; nw++; end
    if (cv) begin
      ci_a[nc % 64] = cidx; cc_a[nc % 64] = ccnt; ce_a[nc % 64] = cerr; cq_a[nc % 64] = irq;
      nc++;
    end
    if (bsy) nb++;
    if (ovr) no++;
    if (irq && !cv) nbirq++;
  end

  function automatic logic [15:0] bcrc(input logic [7:0] x, input logic [7:0] y, input bit sel);
    logic [15:0] r = 16'hFFFF;
    logic [15:0] p = sel ? 16'h8005 : 16'h1021;
    logic [15:0] dd = {x, y};
    for (int k = 15; k >= 0; k--) r = (r[15] ^ dd[k]) ? ({r[14:0], 1'b0} ^ p) : {r[14:0], 1'b0};
    return r;
  endfunction

  function automatic logic [7:0] flip(input logic [7:0] x);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = x[7-k];
    return r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic send_bit(input logic v, input logic pulse);
    @(posedge clk); #2 b = v; bv = 1; sp = pulse;
    @(posedge clk); #2 bv = 0; sp = 0;
  endtask

  task automatic send_byte(input logic [7:0] v, input logic pulse_first);
    for (int k = 7; k >= 0; k--) send_bit(v[k], pulse_first && k == 7);
  endtask

  task automatic send_pat();
    for (int k = 15; k >= 0; k--) send_bit(PAT[k], 1'b0);
  endtask

  task automatic rehunt();
    @(posedge clk); #2 hc = 1;
    @(posedge clk); #2 hc = 0;
    check("R6 hunt command drops sync", ins, 0);
  endtask

  task automatic arm(input int i, input logic ie);
    @(posedge clk); #2 av = 1; aidx = i[1:0]; aie = ie;
    @(posedge clk); #2 av = 0;
  endtask

  // sk: 0 none, 1 pattern, 2 pulse; a/c are the stored payload bytes
  task automatic run_frame(input logic [7:0] a, input logic [7:0] c, input int sk,
                           input bit bad, input int exp_irq, input string tag);
    logic [15:0] cr;
    logic [7:0]  st [4];
    int bw, bc;
    cr = bcrc(a, c, cs);
    st[0] = a; st[1] = c; st[2] = cr[15:8]; st[3] = bad ? ~cr[7:0] : cr[7:0];
    bw = nw; bc = nc;
    if (sk == 1) send_pat();
    for (int k = 0; k < 4; k++) send_byte(rv ? flip(st[k]) : st[k], sk == 2 && k == 0);
    idle(10);
    check({tag, " writes"}, nw - bw, 4);
    for (int k = 0; k < 4; k++) check({tag, " data"}, wd_a[(bw + k) % 256], st[k]);
    check({tag, " write idx"}, wi_a[bw % 256], exp_cur);
    check({tag, " closes"}, nc - bc, 1);
    check({tag, " R11 close idx"}, ci_a[bc % 64], exp_cur);
    check({tag, " R4 count"}, cc_a[bc % 64], BL);
    check({tag, " R10 crc err"}, ce_a[bc % 64], bad ? 1 : 0);
    check({tag, " R4 irq"}, cq_a[bc % 64], exp_irq);
    check({tag, " R2 stays in sync"}, ins, 1);
    exp_cur = (exp_cur + 1) % DN;
  endtask

  task automatic t_reset();
    idle(2);
    check("R1 reset in_sync", ins, 0);
    check("R1 reset empty flags", demp, 0);
    check("R1 reset no writes", nw, 0);
  endtask

  task automatic t_hunt();
    for (int i = 0; i < DN; i++) arm(i, 1'b1);
    repeat (3) send_byte(8'h11, 1'b0);
    idle(6);
    check("R1 hunt stores nothing", nw, 0);
    check("R1 still hunting", ins, 0);
  endtask

  task automatic t_pattern();
    run_frame(8'h3C, 8'h96, 1, 0, 1, "R2 pattern frame");
    check("R4 empty flag cleared", demp[0], 0);
  endtask

  task automatic t_crc();
    cs = 1;
    run_frame(8'h5A, 8'h0F, 0, 0, 1, "R10 poly8005 good");
    run_frame(8'h77, 8'hE1, 0, 1, 1, "R10 poly8005 bad");
    cs = 0;
  endtask

  task automatic t_rev();
    rehunt();
    rv = 1;
    run_frame(8'h12, 8'hC8, 1, 0, 1, "R9 reversed frame");
    rv = 0;
  endtask

  task automatic t_pulse();
    rehunt();
    arm(0, 1'b0);
    pm = 1;
    run_frame(8'hB4, 8'h2D, 2, 0, 0, "R3 pulse frame");
    pm = 0;
  endtask

  task automatic t_busy();
    int b0, w0;
    rehunt();
    bie = 1; b0 = nbirq; w0 = nw;
    send_pat();
    send_byte(8'h44, 1'b0);
    idle(6);
    check("R5 busy event", nb, 1);
    check("R5 busy irq", nbirq - b0, 1);
    check("R5 back to hunt", ins, 0);
    check("R5 nothing written", nw - w0, 0);
    bie = 0;
  endtask

  task automatic t_cd();
    int c0;
    rehunt();
    arm(1, 1'b0); arm(2, 1'b1);
    c0 = nc;
    send_pat();
    send_byte(8'h01, 1'b0); send_byte(8'h02, 1'b0);
    idle(6);
    @(posedge clk); #2 cd = 0;
    idle(4);
    check("R6 carrier loss drops sync", ins, 0);
    check("R6 partial close", nc - c0, 1);
    check("R6 partial idx", ci_a[c0 % 64], exp_cur);
    check("R6 partial count", cc_a[c0 % 64], 2);
    check("R6 partial irq off", cq_a[c0 % 64], 0);
    exp_cur = (exp_cur + 1) % DN;
    cd = 1;
    idle(2);
  endtask

  task automatic t_ovr();
    int o0, w0;
    rehunt();
    rdy = 0; nar = 1; o0 = no; w0 = nw;
    send_pat();
    send_byte(8'hAA, 1'b0);
    idle(3);
    check("R8 narrow holds one", no - o0, 0);
    send_byte(8'hAB, 1'b0);
    idle(3);
    check("R7 R8 narrow overrun", no - o0, 1);
    check("R7 overrun hunts", ins, 0);
    nar = 0;
    send_pat();
    for (int k = 0; k < 4; k++) send_byte(8'hC0, 1'b0);
    idle(3);
    check("R8 wide holds four", no - o0, 1);
    check("R8 still synced", ins, 1);
    send_byte(8'hC5, 1'b0);
    idle(3);
    check("R7 wide overrun", no - o0, 2);
    rdy = 1;
    idle(6);
    check("R7 flushed bytes not written", nw - w0, 0);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    t_reset();
    en = 1; cd = 1;
    idle(2);
    t_hunt();
    t_pattern();
    t_crc();
    t_rev();
    t_pulse();
    t_busy();
    t_cd();
    t_ovr();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule